// File: doc/BRIEF.md
# Bus Strobe Rebuilder with Interrupt-Enable Register

This block sits beside a Z80-compatible CMOS processor that has no separate memory-request and I/O-request strobes. That processor gives a level select line (`io_sel`) and separate active-low read and write strobes. The select line becomes valid together with the address, so it cannot mark the timing of an access by itself. The block combines the read and write strobes into one access signal. It then gates the select line with that signal to produce two active-low request strobes, one for memory and one for I/O. These strobes are combinational and have no added clock latency.

The block also holds a write-only interrupt-enable register at I/O address 0xBB. Bit 0 enables the main maskable interrupt input and is set after reset. Bits 1 to 3 enable three more interrupt inputs and are clear after reset. A single combined interrupt request goes back to the processor. The register contents are also available on a port so that the rest of the system can see them.

Top module: `strobe_rebuild_top`

## Requirements
- R1: `io_req_n` is low in the same cycle exactly when `rst_n` is high, `io_sel` is 1 (1 = I/O, 0 = memory), and `rd_n` or `wr_n` is low.
- R2: `mem_req_n` is low in the same cycle exactly when `rst_n` is high, `io_sel` is 0, and `rd_n` or `wr_n` is low.
- R3: While `rst_n` is low, or while both `rd_n` and `wr_n` are high, both request strobes are high.
- R4: `mem_req_n` and `io_req_n` are never low together.
- R5: An I/O write to address 0xBB (low 8 address bits) loads `data_in[3:0]` into the register. The load happens at the first clock edge that samples `wr_n` high after an edge that sampled `wr_n` low with `io_sel`=1 and address 0xBB. The data used is the value sampled at that last low edge.
- R6: A synchronous reset (`rst_n` low at a clock edge) sets the register to 4'b0001.
- R7: Writes to any other I/O address, memory writes to 0xBB and I/O reads of 0xBB leave `ien_q` unchanged.
- R8: `irq_out` is high exactly when `irq_in[i]` and `ien_q[i]` are both high for some i.
- R9: Register bit i enables `irq_in[i]`: bit 0 enables the main interrupt input `irq_in[0]`, and bits 1 to 3 enable `irq_in[3:1]`. `data_in[7:4]` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | Level select: 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_lo | input | 8 | Low address byte |
| data_in | input | 8 | Data bus as seen during writes |
| irq_in | input | 4 | Active-high interrupt inputs; bit 0 is the main input |
| mem_req_n | output | 1 | Rebuilt active-low memory-request strobe |
| io_req_n | output | 1 | Rebuilt active-low I/O-request strobe |
| ien_q | output | 4 | Interrupt-enable register contents |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume three things about the inputs. The write strobe stays low for at least one clock edge. The select line, the address and the data are stable at the edge that samples the write strobe low. Read and write strobes follow the bus protocol. The bench drives inputs only one time unit after a rising edge and holds them for a full cycle. Every write therefore spans at least two sampled-low edges and then returns high, with address and data held constant. Checks sample at the falling edge, once the combinational strobes and the register have settled.

// File: rtl/strobe_rebuild_pkg.sv
// Package: shared constants for the strobe rebuilder and its enable register.
// Assumes an 8-bit decoded address and four interrupt inputs by default.
package strobe_rebuild_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NIRQ     = 4;
    localparam logic [ADDR_W-1:0] IEN_ADDR = 8'hBB;
    localparam logic [NIRQ-1:0]   IEN_RST  = 4'b0001;
endpackage

// File: rtl/strobe_gen.sv
// Module: strobe_gen
// Builds memory and I/O request strobes from the level select line gated by
// the combined read/write activity. Purely combinational; assumes io_sel is
// stable whenever a strobe is low.
module strobe_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic io_sel,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_req_n,
    output logic io_req_n
);
    logic access;

    // Combine the two strobes and gate the select line with the result
    always_comb begin
        access    = rst_n & (~rd_n | ~wr_n);
        io_req_n  = ~(access & io_sel);
        mem_req_n = ~(access & ~io_sel);
    end

    // R4
    req_excl_chk: assert property (@(posedge clk) !(!mem_req_n && !io_req_n));
    // R3
    req_idle_chk: assert property (@(posedge clk) (!rst_n || (rd_n && wr_n)) |-> (mem_req_n && io_req_n));
    // R1
    io_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n) !io_req_n |-> io_sel);
    // R2
    mem_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n) !mem_req_n |-> !io_sel);
endmodule

// File: rtl/ien_reg.sv
// Module: ien_reg
// Write-only interrupt-enable register decoded on the low address byte.
// Captures the target match and data while the write strobe is low, and
// commits at the first edge that sees the strobe high again.
// Assumes address and data are stable at the last low-sampled edge.
module ien_reg #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NIRQ   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hBB,
    parameter logic [NIRQ-1:0]   RST_VAL  = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] data_in,
    output logic [NIRQ-1:0]   ien_q
);
    logic            hit_q;
    logic [NIRQ-1:0] cap_q;

    // Capture decode and data while the write strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            cap_q <= '0;
        end else if (!wr_n) begin
            hit_q <= io_sel && (addr_lo == REG_ADDR);
            cap_q <= data_in[NIRQ-1:0];
        end else begin
            hit_q <= 1'b0;
        end
    end

    // Commit the captured value on the strobe's return high
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= RST_VAL;
        else if (hit_q && wr_n)
            ien_q <= cap_q;
    end

    // R6
    ien_rst_chk: assert property (@(posedge clk) !rst_n |=> (ien_q == RST_VAL));
    // R7
    ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_n) |=> $stable(ien_q));
endmodule

// File: rtl/irq_merge.sv
// Module: irq_merge
// Masks each interrupt input with its enable bit and ORs the results.
// Assumes inputs are already synchronous to clk.
module irq_merge #(
    parameter int unsigned NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_in,
    input  logic [NIRQ-1:0] ien,
    output logic            irq_out
);
    logic [NIRQ-1:0] masked;

    // Per-input gating
    for (genvar i = 0; i < NIRQ; i++) begin : g_mask
        assign masked[i] = irq_in[i] & ien[i];
    end

    // Reduce to one request line
    always_comb irq_out = |masked;

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> ((irq_in & ien) != '0));
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq_in == '0) |-> !irq_out);
endmodule

// File: rtl/strobe_rebuild_top.sv
// Module: strobe_rebuild_top
// Rebuilds memory/I/O request strobes for a processor with a level select
// line and hosts the write-only interrupt-enable register with its merge.
// Assumes synchronous active-low reset and inputs synchronous to clk.
module strobe_rebuild_top
    import strobe_rebuild_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] data_in,
    input  logic [NIRQ-1:0]   irq_in,
    output logic              mem_req_n,
    output logic              io_req_n,
    output logic [NIRQ-1:0]   ien_q,
    output logic              irq_out
);
    // Strobe rebuild
    strobe_gen u_strobe (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n),
        .mem_req_n(mem_req_n), .io_req_n(io_req_n)
    );

    // Enable register
    ien_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIRQ(NIRQ),
        .REG_ADDR(IEN_ADDR), .RST_VAL(IEN_RST)
    ) u_ien (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .wr_n(wr_n),
        .addr_lo(addr_lo), .data_in(data_in), .ien_q(ien_q)
    );

    // Interrupt merge
    irq_merge #(.NIRQ(NIRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ien(ien_q), .irq_out(irq_out)
    );
endmodule

// File: tb/strobe_rebuild_top_bench.sv
`timescale 1ns/100ps
module strobe_rebuild_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_sel = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr_lo = 8'h00;
    logic [7:0] data_in = 8'h00;
    logic [3:0] irq_in = 4'h0;
    logic       mem_req_n, io_req_n, irq_out;
    logic [3:0] ien_q;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strobe_rebuild_top u_strobe_rebuild_top (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n),
        .addr_lo(addr_lo), .data_in(data_in), .irq_in(irq_in),
        .mem_req_n(mem_req_n), .io_req_n(io_req_n), .ien_q(ien_q), .irq_out(irq_out)
    );

    typedef struct {
        string      tag;
        logic       mreq_n;
        logic       ioreq_n;
        bit         chk_ien;
        logic [3:0] ien;
        logic       irq;
    } exp_t;
    exp_t sb[$];

    // reference model history: previous step (h1) and the one before (h2)
    logic       h1_rst = 0, h1_wr = 1;
    logic       h2_rst = 0, h2_wr = 1, h2_io = 0;
    logic [7:0] h2_addr = 0, h2_data = 0;
    logic [3:0] m_ien = 4'h0;
    bit         m_known = 0;

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected outputs
    task automatic step(string tag, logic r, logic io, logic rd, logic wr,
                        logic [7:0] a, logic [7:0] d, logic [3:0] irq);
        exp_t e;
        logic acc;
        @(posedge clk);
        #1;
        // register state after the edge just passed
        if (!h1_rst) begin
            m_ien = 4'b0001; m_known = 1;
        end else if (h2_rst && !h2_wr && h2_io && h2_addr == 8'hBB && h1_wr) begin
            m_ien = h2_data[3:0];
        end
        rst_n = r; io_sel = io; rd_n = rd; wr_n = wr; addr_lo = a; data_in = d; irq_in = irq;
        acc = r & (~rd | ~wr);
        e.tag = tag;
        e.ioreq_n = ~(acc & io);
        e.mreq_n = ~(acc & ~io);
        e.chk_ien = m_known;
        e.ien = m_ien;
        e.irq = |(irq & m_ien);
        sb.push_back(e);
        h2_rst = h1_rst; h2_wr = h1_wr; h2_io = io_sel_prev; h2_addr = addr_prev; h2_data = data_prev;
        h1_rst = r; h1_wr = wr; io_sel_prev = io; addr_prev = a; data_prev = d;
    endtask
    logic       io_sel_prev = 0;
    logic [7:0] addr_prev = 0, data_prev = 0;

    // Monitor: pop and compare at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "mem_req_n", {3'b0, mem_req_n}, {3'b0, e.mreq_n});
            check(e.tag, "io_req_n", {3'b0, io_req_n}, {3'b0, e.ioreq_n});
            if (e.chk_ien) begin
                check(e.tag, "ien_q", ien_q, e.ien);
                check(e.tag, "irq_out", {3'b0, irq_out}, {3'b0, e.irq});
            end
        end
    end

    task automatic io_write(string tag, logic [7:0] a, logic [7:0] d);
        step(tag, 1, 1, 1, 0, a, d, 4'h0);
        step(tag, 1, 1, 1, 0, a, d, 4'h0);
        step(tag, 1, 1, 1, 1, a, d, 4'h0);
        step(tag, 1, 0, 1, 1, 8'h00, 8'h00, 4'h0);
    endtask

    initial begin
        // R3 R6: strobes idle during reset even with write active
        step("R3_reset", 0, 1, 1, 0, 8'hBB, 8'h0E, 4'h0);
        step("R6_reset", 0, 0, 0, 1, 8'h00, 8'h00, 4'h0);
        step("R6_after", 1, 0, 1, 1, 8'h00, 8'h00, 4'h0);
        step("R3_idle", 1, 1, 1, 1, 8'hBB, 8'h00, 4'h0);
        // R2 memory accesses
        step("R2_mem_rd", 1, 0, 0, 1, 8'h12, 8'h00, 4'h0);
        step("R2_mem_wr", 1, 0, 1, 0, 8'h34, 8'h55, 4'h0);
        step("R4_gap", 1, 0, 1, 1, 8'h34, 8'h55, 4'h0);
        // R1 I/O read
        step("R1_io_rd", 1, 1, 0, 1, 8'h20, 8'h00, 4'h0);
        step("R1_io_rd", 1, 1, 0, 1, 8'h20, 8'h00, 4'h0);
        // R8 R9 reset enables
        step("R8_intr", 1, 0, 1, 1, 8'h00, 8'h00, 4'b0001);
        step("R9_masked", 1, 0, 1, 1, 8'h00, 8'h00, 4'b1110);
        // R5 R9 load with upper data bits set
        io_write("R5_load", 8'hBB, 8'hF6);
        step("R9_en1", 1, 0, 1, 1, 8'h00, 8'h00, 4'b0010);
        step("R9_dis0", 1, 0, 1, 1, 8'h00, 8'h00, 4'b0001);
        // R7 no effect: other address, memory write, I/O read of target
        io_write("R7_other", 8'hBA, 8'h0F);
        step("R7_memwr", 1, 0, 1, 0, 8'hBB, 8'h09, 4'h0);
        step("R7_memwr", 1, 0, 1, 0, 8'hBB, 8'h09, 4'h0);
        step("R7_memwr", 1, 0, 1, 1, 8'hBB, 8'h09, 4'h0);
        step("R7_iord", 1, 1, 0, 1, 8'hBB, 8'h09, 4'h0);
        step("R7_iord", 1, 1, 1, 1, 8'hBB, 8'h09, 4'h0);
        step("R7_hold", 1, 0, 1, 1, 8'h00, 8'h00, 4'b0001);
        // R5 all enables
        io_write("R5_all", 8'hBB, 8'h0F);
        step("R8_top", 1, 0, 1, 1, 8'h00, 8'h00, 4'b1000);
        // R6 reset mid-run
        step("R6_again", 0, 0, 1, 1, 8'h00, 8'h00, 4'b1000);
        step("R6_again", 1, 0, 1, 1, 8'h00, 8'h00, 4'b1000);
        step("R6_again", 1, 0, 1, 1, 8'h00, 8'h00, 4'b0001);
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule